// File: doc/BRIEF.md
# Program Counter and Return Stack Unit

This unit owns the program counter of a small 8-bit interpreter-style CPU. It also owns a return stack that is kept in main memory rather than in dedicated registers. An upstream fetch/decode stage hands it one 16-bit control-flow opcode at a time, with a one-cycle `issue` strobe. The unit carries out six kinds of work: absolute jumps, jumps offset by register 0, conditional skips, subroutine calls and returns. It also flags words that do not belong to its group.

Register operands come from an external register file through two combinational read ports. The unit drives the port indices, and the file answers in the same cycle. Calls and returns move a 16-bit return address through a byte-wide synchronous memory port that has a ready handshake. The word is stored most significant byte first. The stack grows toward lower addresses, one 2-byte slot per call.

Single-cycle operations finish at the edge that accepts them. Stack operations run a two-access sequence, and `busy` stays high while the sequence runs. In both cases a registered `done` pulse marks the end of the instruction.

Top module: `pcu_top`

## Requirements
- R1: While reset is applied, and at its release, `pc` equals parameter RESET_PC and `sp` equals RESET_SP, and `busy`, `done`, `illegal` and `mem_req` are all low.
- R2: A word 0x1aaa (top nibble 1) sets `pc` to the zero-extended 12-bit field aaa.
- R3: A word 0xBaaa sets `pc` to aaa plus the zero-extended value of register 0. For this word `rf_x_idx` is 0.
- R4: A word 0x3xbb adds 2 to `pc` when register x (bits 11:8) equals the byte bb (bits 7:0). A word 0x4xbb adds 2 when they differ. Otherwise `pc` is unchanged.
- R5: A word 0x5xy0 adds 2 to `pc` when register x equals register y (bits 7:4). A word 0x9xy0 adds 2 when they differ. Otherwise `pc` is unchanged.
- R6: A word 0x2aaa writes the current `pc` into memory, high byte at address `sp` and low byte at `sp`+1. It then lowers `sp` by 2 and sets `pc` to aaa.
- R7: The word 0x00EE reads the high byte at `sp`+2 and the low byte at `sp`+3. It loads that 16-bit word into `pc` and raises `sp` by 2.
- R8: Any other word is illegal. Examples are 0x00E0, a 5/9 word with nonzero low nibble, and any other top nibble. An illegal word pulses `illegal` together with `done`, leaves `pc` and `sp` unchanged, and makes no memory access.
- R9: All `pc` and `sp` arithmetic wraps modulo 2^16. For example, a taken skip at 0xFFFE gives 0x0000, and a call with `sp`=0 leaves `sp`=0xFFFE.
- R10: `mem_req` is only high while `busy` is high. An access completes on a cycle where `mem_req` and `mem_ready` are both high. Wait states stall the sequence. `busy` stays high until the last access completes.
- R11: `done` is high for exactly one cycle, in the cycle after the edge that makes the final `pc`/`sp` update. An `issue` while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | Opcode valid strobe |
| opcode | input | 16 | Control-flow instruction word |
| rf_x_idx | output | 4 | Register file read index, port X |
| rf_y_idx | output | 4 | Register file read index, port Y |
| rf_x_data | input | 8 | Register value for port X |
| rf_y_data | input | 8 | Register value for port Y |
| mem_req | output | 1 | Stack memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid when ready |
| mem_ready | input | 1 | Access completes this cycle |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| busy | output | 1 | Stack access sequence in progress |
| done | output | 1 | Instruction complete pulse |
| illegal | output | 1 | Illegal opcode pulse |

## Verification
The bench builds the unit with RESET_PC = 0xFFFE and RESET_SP = 0x0000, so both wrap boundaries are hit in the first few instructions. The first taken skip crosses the top of the PC range. The first call stores its slot at address 0 and takes the stack pointer below zero, and the matching return must read back across the same boundary. The memory model gives randomly delayed ready, so every call and return is also tested with wait states between its two byte accesses.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 2 * BYTE_W;
  localparam int NIB_W   = 4;
  localparam int FIELD_W = WORD_W - NIB_W;

  typedef enum logic [3:0] {
    OP_JMP, OP_JIDX, OP_CALL, OP_RET,
    OP_SEQI, OP_SNEI, OP_SEQR, OP_SNER, OP_BAD
  } pcu_op_e;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_WHI, SQ_WLO, SQ_RHI, SQ_RLO
  } pcu_seq_e;

  function automatic pcu_op_e classify(input logic [WORD_W-1:0] w);
    pcu_op_e r;
    case (w[WORD_W-1 -: NIB_W])
      4'h0:    r = (w == 16'h00EE) ? OP_RET : OP_BAD;
      4'h1:    r = OP_JMP;
      4'h2:    r = OP_CALL;
      4'h3:    r = OP_SEQI;
      4'h4:    r = OP_SNEI;
      4'h5:    r = (w[NIB_W-1:0] == '0) ? OP_SEQR : OP_BAD;
      4'h9:    r = (w[NIB_W-1:0] == '0) ? OP_SNER : OP_BAD;
      4'hB:    r = OP_JIDX;
      default: r = OP_BAD;
    endcase
    return r;
  endfunction

  function automatic logic skip_taken(input pcu_op_e op, input logic [BYTE_W-1:0] vx,
                                      input logic [BYTE_W-1:0] vy, input logic [BYTE_W-1:0] imm);
    case (op)
      OP_SEQI: return vx == imm;
      OP_SNEI: return vx != imm;
      OP_SEQR: return vx == vy;
      OP_SNER: return vx != vy;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] step_pc(input logic [WORD_W-1:0] p);
    return p + WORD_W'(2);
  endfunction

  function automatic logic [WORD_W-1:0] indexed_target(input logic [FIELD_W-1:0] a,
                                                       input logic [BYTE_W-1:0] v0);
    return WORD_W'(a) + WORD_W'(v0);
  endfunction
endpackage

// File: rtl/pcu_decode.sv
module pcu_decode
  import pcu_pkg::*;
(
  input  logic [WORD_W-1:0]  opcode,
  output pcu_op_e            op,
  output logic [NIB_W-1:0]   x_idx,
  output logic [NIB_W-1:0]   y_idx,
  output logic [BYTE_W-1:0]  imm8,
  output logic [FIELD_W-1:0] addr
);
  always_comb begin
    op    = classify(opcode);
    x_idx = (op == OP_JIDX) ? '0 : opcode[FIELD_W-1 -: NIB_W];
    y_idx = opcode[BYTE_W-1 -: NIB_W];
    imm8  = opcode[BYTE_W-1:0];
    addr  = opcode[FIELD_W-1:0];
  end
endmodule

// File: rtl/pcu_flow.sv
module pcu_flow
  import pcu_pkg::*;
(
  input  pcu_op_e            op,
  input  logic [WORD_W-1:0]  pc_cur,
  input  logic [FIELD_W-1:0] addr,
  input  logic [BYTE_W-1:0]  imm8,
  input  logic [BYTE_W-1:0]  vx,
  input  logic [BYTE_W-1:0]  vy,
  output logic [WORD_W-1:0]  pc_next,
  output logic               skip_hit
);
  always_comb begin
    skip_hit = skip_taken(op, vx, vy, imm8);
    case (op)
      OP_JMP:  pc_next = WORD_W'(addr);
      OP_JIDX: pc_next = indexed_target(addr, vx);
      OP_SEQI, OP_SNEI, OP_SEQR, OP_SNER:
               pc_next = skip_hit ? step_pc(pc_cur) : pc_cur;
      default: pc_next = pc_cur;
    endcase
  end
endmodule

// File: rtl/pcu_stack_seq.sv
module pcu_stack_seq
  import pcu_pkg::*;
#(
  parameter logic [15:0] RESET_SP = 16'h0EFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_call,
  input  logic              go_ret,
  input  logic [WORD_W-1:0] save_word,
  input  logic              mem_ready,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic [WORD_W-1:0] sp,
  output logic              busy,
  output logic              fin_call,
  output logic              fin_ret,
  output logic [WORD_W-1:0] ret_word
);
  localparam logic [WORD_W-1:0] SLOT = WORD_W'(WORD_W / BYTE_W);

  pcu_seq_e          state;
  logic [WORD_W-1:0] save_q;
  logic [BYTE_W-1:0] hi_q;
  logic [WORD_W-1:0] off;

  always_comb begin
    mem_req = (state != SQ_IDLE);
    mem_we  = (state == SQ_WHI) || (state == SQ_WLO);
    busy    = mem_req;
    case (state)
      SQ_WLO:  off = WORD_W'(1);
      SQ_RHI:  off = WORD_W'(2);
      SQ_RLO:  off = WORD_W'(3);
      default: off = '0;
    endcase
    mem_addr  = sp + off;
    mem_wdata = (state == SQ_WHI) ? save_q[WORD_W-1 -: BYTE_W] : save_q[BYTE_W-1:0];
    fin_call  = (state == SQ_WLO) && mem_ready;
    fin_ret   = (state == SQ_RLO) && mem_ready;
    ret_word  = {hi_q, mem_rdata};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SQ_IDLE;
      sp     <= RESET_SP;
      save_q <= '0;
      hi_q   <= '0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (go_call) begin
            save_q <= save_word;
            state  <= SQ_WHI;
          end else if (go_ret) begin
            state  <= SQ_RHI;
          end
        end
        SQ_WHI: if (mem_ready) state <= SQ_WLO;
        SQ_WLO: if (mem_ready) begin
          sp    <= sp - SLOT;
          state <= SQ_IDLE;
        end
        SQ_RHI: if (mem_ready) begin
          hi_q  <= mem_rdata;
          state <= SQ_RLO;
        end
        SQ_RLO: if (mem_ready) begin
          sp    <= sp + SLOT;
          state <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pcu_top.sv
module pcu_top
  import pcu_pkg::*;
#(
  parameter logic [15:0] RESET_PC = 16'h0200,
  parameter logic [15:0] RESET_SP = 16'h0EFE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        issue,
  input  logic [15:0] opcode,
  output logic [3:0]  rf_x_idx,
  output logic [3:0]  rf_y_idx,
  input  logic [7:0]  rf_x_data,
  input  logic [7:0]  rf_y_data,
  output logic        mem_req,
  output logic        mem_we,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  input  logic        mem_ready,
  output logic [15:0] pc,
  output logic [15:0] sp,
  output logic        busy,
  output logic        done,
  output logic        illegal
);
  pcu_op_e            op;
  logic [BYTE_W-1:0]  imm8;
  logic [FIELD_W-1:0] addr;
  logic [WORD_W-1:0]  pc_next;
  logic               skip_hit;
  logic               accept, go_call, go_ret, go_bad, go_single;
  logic               fin_call, fin_ret;
  logic [WORD_W-1:0]  ret_word;
  logic [WORD_W-1:0]  target_q;
  logic               done_q, illegal_q;

  pcu_decode u_dec (
    .opcode(opcode), .op(op), .x_idx(rf_x_idx), .y_idx(rf_y_idx),
    .imm8(imm8), .addr(addr)
  );

  pcu_flow u_flow (
    .op(op), .pc_cur(pc), .addr(addr), .imm8(imm8),
    .vx(rf_x_data), .vy(rf_y_data), .pc_next(pc_next), .skip_hit(skip_hit)
  );

  pcu_stack_seq #(.RESET_SP(RESET_SP)) u_seq (
    .clk(clk), .rst_n(rst_n), .go_call(go_call), .go_ret(go_ret),
    .save_word(pc), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .sp(sp), .busy(busy), .fin_call(fin_call), .fin_ret(fin_ret), .ret_word(ret_word)
  );

  always_comb begin
    accept    = issue && !busy;
    go_call   = accept && (op == OP_CALL);
    go_ret    = accept && (op == OP_RET);
    go_bad    = accept && (op == OP_BAD);
    go_single = accept && !go_call && !go_ret && !go_bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc        <= RESET_PC;
      target_q  <= '0;
      done_q    <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      if (go_single)     pc <= pc_next;
      else if (fin_call) pc <= target_q;
      else if (fin_ret)  pc <= ret_word;
      if (go_call) target_q <= WORD_W'(addr);
      done_q    <= go_single || go_bad || fin_call || fin_ret;
      illegal_q <= go_bad;
    end
  end

  assign done    = done_q;
  assign illegal = illegal_q;
endmodule

// File: rtl/pcu_top_chk.sv
module pcu_top_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        issue,
  input logic [15:0] opcode,
  input logic [7:0]  rf_x_data,
  input logic        mem_req,
  input logic [15:0] pc,
  input logic [15:0] sp,
  input logic        busy,
  input logic        done,
  input logic        illegal
);
  AST_REQ_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy); // R10

  AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R11

  AST_JUMP_LOADS_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !busy && opcode[15:12] == 4'h1) |=> pc == {4'h0, $past(opcode[11:0])}); // R2

  AST_SKIP_IMM_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !busy && opcode[15:12] == 4'h3 && rf_x_data == opcode[7:0])
      |=> pc == $past(pc) + 16'd2); // R4

  AST_SP_MOVES_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (sp != $past(sp)) |-> done); // R6

  AST_ILLEGAL_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (pc == $past(pc) && sp == $past(sp))); // R8
endmodule

bind pcu_top pcu_top_chk chk_i (
  .clk(clk), .rst_n(rst_n), .issue(issue), .opcode(opcode), .rf_x_data(rf_x_data),
  .mem_req(mem_req), .pc(pc), .sp(sp), .busy(busy), .done(done), .illegal(illegal)
);

// File: tb/pcu_top_tb_top.sv
module pcu_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] T_RESET_PC = 16'hFFFE;
  localparam logic [15:0] T_RESET_SP = 16'h0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0;
  logic [15:0] opcode = 16'h0000;
  logic [3:0]  rf_x_idx, rf_y_idx;
  logic [7:0]  rf_x_data, rf_y_data;
  logic        mem_req, mem_we, mem_ready = 1'b0;
  logic [15:0] mem_addr, pc, sp;
  logic [7:0]  mem_wdata, mem_rdata = 8'h00;
  logic        busy, done, illegal;

  logic [7:0] vreg [16];
  logic [7:0] mem [logic [15:0]];
  int n_tests = 0;
  int n_fail = 0;
  logic [15:0] m_pc, m_sp;
  bit force_ready = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rf_x_data = vreg[rf_x_idx];
  assign rf_y_data = vreg[rf_y_idx];

  pcu_top #(.RESET_PC(T_RESET_PC), .RESET_SP(T_RESET_SP)) dut_i (
    .clk(clk), .rst_n(rst_n), .issue(issue), .opcode(opcode),
    .rf_x_idx(rf_x_idx), .rf_y_idx(rf_y_idx), .rf_x_data(rf_x_data), .rf_y_data(rf_y_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .pc(pc), .sp(sp), .busy(busy), .done(done), .illegal(illegal)
  );

  function automatic logic [7:0] rd(input logic [15:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  always @(negedge clk) begin
    mem_ready = force_ready || (($urandom % 4) != 0);
    if (mem_req && mem_we && mem_ready) mem[mem_addr] = mem_wdata;
    mem_rdata = rd(mem_addr);
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [15:0] w, input string req, input bit stray = 1'b0);
    logic [3:0]  nib = w[15:12];
    logic [7:0]  vx = vreg[w[11:8]];
    logic [7:0]  vy = vreg[w[7:4]];
    bit          e_ill = 1'b0, is_call = 1'b0, ill_seen, pulse_ok, req_ok = 1'b1;
    logic [15:0] saved = m_pc, slot = m_sp;
    int n = 0;
    case (nib)
      4'h1: m_pc = {4'h0, w[11:0]};
      4'hB: m_pc = {4'h0, w[11:0]} + {8'h00, vreg[0]};
      4'h2: begin is_call = 1'b1; m_sp = m_sp - 16'd2; m_pc = {4'h0, w[11:0]}; end
      4'h0: if (w == 16'h00EE) begin
              m_pc = {rd(m_sp + 16'd2), rd(m_sp + 16'd3)}; m_sp = m_sp + 16'd2;
            end else e_ill = 1'b1;
      4'h3: if (vx == w[7:0]) m_pc = m_pc + 16'd2;
      4'h4: if (vx != w[7:0]) m_pc = m_pc + 16'd2;
      4'h5: if (w[3:0] != 0) e_ill = 1'b1; else if (vx == vy) m_pc = m_pc + 16'd2;
      4'h9: if (w[3:0] != 0) e_ill = 1'b1; else if (vx != vy) m_pc = m_pc + 16'd2;
      default: e_ill = 1'b1;
    endcase
    @(negedge clk); opcode = w; issue = 1'b1;
    @(posedge clk);
    @(negedge clk);
    if (stray) begin
      opcode = 16'h1777;
      @(posedge clk);
      @(negedge clk);
    end
    issue = 1'b0;
    while (!done && n < 200) begin
      if (mem_req && !busy) req_ok = 1'b0;
      @(negedge clk); n++;
    end
    ill_seen = illegal;
    @(negedge clk); pulse_ok = !done;
    check(pc == m_pc, {req, " pc"}, pc, m_pc);
    check(sp == m_sp, {req, " sp"}, sp, m_sp);
    check(ill_seen == e_ill, {req, " illegal R8"}, ill_seen, e_ill);
    check(pulse_ok && n < 200, {req, " done pulse R11"}, n, 0);
    check(req_ok, {req, " mem_req inside busy R10"}, req_ok, 1);
    if (is_call)
      check({rd(slot), rd(slot + 16'd1)} == saved, {req, " stacked word R6"},
            {rd(slot), rd(slot + 16'd1)}, saved);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R11 actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) vreg[i] = 8'(i * 17);
    m_pc = T_RESET_PC; m_sp = T_RESET_SP;
    repeat (3) @(negedge clk);
    check(pc == T_RESET_PC && sp == T_RESET_SP, "R1 reset pc/sp", {pc, sp}, {T_RESET_PC, T_RESET_SP});
    check(!busy && !done && !illegal && !mem_req, "R1 reset flags",
          {busy, done, illegal, mem_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(pc == T_RESET_PC && !busy && !done, "R1 after release", pc, T_RESET_PC);

    vreg[3] = 8'h5A;
    run_op(16'h335A, "R4 R9 skip-eq taken wraps");
    run_op(16'h435A, "R4 skip-ne not taken");
    run_op(16'h3300, "R4 skip-eq not taken");
    run_op(16'h1ABC, "R2 jump");
    vreg[0] = 8'hFF;
    run_op(16'hBFFF, "R3 indexed max");
    vreg[4] = 8'h11; vreg[5] = 8'h11;
    run_op(16'h5450, "R5 reg-eq taken");
    run_op(16'h9450, "R5 reg-ne not taken");
    run_op(16'h2345, "R6 R9 call below zero");
    run_op(16'h00EE, "R7 R9 return across zero");
    run_op(16'h00E0, "R8 clear-screen word");
    run_op(16'h5451, "R8 nonzero low nibble");
    run_op(16'h6012, "R8 foreign group");
    force_ready = 1'b1;
    run_op(16'h2456, "R11 issue during busy ignored", 1'b1);
    force_ready = 1'b0;

    for (int k = 0; k < 400; k++) begin
      logic [15:0] w;
      int x = $urandom % 16, y = $urandom % 16;
      for (int r = 0; r < 16; r++) vreg[r] = 8'($urandom);
      if ($urandom % 2) vreg[y] = vreg[x];
      case ($urandom % 9)
        0: run_op({4'h1, 12'($urandom)}, "R2 random jump");
        1: run_op({4'hB, 12'($urandom)}, "R3 random indexed");
        2: run_op({4'h2, 12'($urandom)}, "R6 random call");
        3: run_op(16'h00EE, "R7 random return");
        4: begin w = {4'h3, 4'(x), (($urandom % 2) ? vreg[x] : 8'($urandom))}; run_op(w, "R4 random eq-imm"); end
        5: begin w = {4'h4, 4'(x), (($urandom % 2) ? vreg[x] : 8'($urandom))}; run_op(w, "R4 random ne-imm"); end
        6: run_op({4'h5, 4'(x), 4'(y), 4'h0}, "R5 random eq-reg");
        7: run_op({4'h9, 4'(x), 4'(y), 4'h0}, "R5 random ne-reg");
        default: run_op({4'h8, 12'($urandom)}, "R8 random illegal");
      endcase
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule